// File: doc/BRIEF.md
# Configuration Entry Key Sequencer

This block snoops byte writes on a simple I/O bus (address, data, write strobe) and decides when a peripheral controller may enter its configuration state. Entry takes two stages. In the first stage four bytes go to a fixed configuration port at 0x0279. These four bytes also choose one of three base addresses. In the second stage a 32-byte pseudo-random key must arrive, in order, at the chosen base address.

When the last key byte matches, the block raises a configuration-mode flag and shows the selected base on its output. While the flag is high, the base address acts as an index port and the address above it acts as a data port. Writing the value 0x02 to configuration index 0x02 through that pair leaves configuration mode.

The block generates the key on the fly with an 8-bit shift register, so no key table is stored. It returns to its idle stage on any mismatch.

Top module: `cfg_unlock_seq`

## Requirements
- R1: A synchronous active-high reset clears the mode flag (`cfgMode` low) and returns the sequencer to its idle stage. From the cycle after reset, `cfgBase` reads 0.
- R2: The port bytes 0x86, 0x80, 0x55, 0x55, followed by the full key at 0x03F0, enter configuration mode with `cfgBase` = 0x03F0.
- R3: The port bytes 0x86, 0x80, 0x55, 0xAA select base 0x03BD. The port bytes 0x86, 0x80, 0xAA, 0x55 select base 0x0370. Any other fourth byte after 0x86, 0x80, 0xAA (for example 0xAA) selects nothing.
- R4: The key is 32 bytes long. It starts at 0x6A, and each following byte is the previous byte shifted right by one, with bit0 XOR bit1 of the previous byte placed in bit 7. `cfgMode` rises in the cycle after the clock edge that samples the 32nd matching byte, and it stays low after only 31 bytes.
- R5: A wrong byte at the configuration port during the first stage sends the sequencer back to idle. If that wrong byte is 0x86, it counts as the first byte of a new prefix.
- R6: A wrong key byte at the selected base sends the sequencer back to idle. Later key bytes then have no effect until a new prefix is written.
- R7: Three kinds of write leave the current progress unchanged: a write to an address other than the one the current stage expects, a write to the configuration port during the key stage or in configuration mode, and any cycle with `ioWr` low.
- R8: In configuration mode, a write to the base address loads the index, and a write to base+1 writes data. Writing data 0x02 while the index is 0x02 drops `cfgMode` one cycle later. Any other index or data value leaves the mode flag set.
- R9: `cfgBase` holds the selected base while `cfgMode` is high and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioAddr | input | 16 | I/O write address |
| ioData | input | 8 | I/O write data byte |
| ioWr | input | 1 | Write strobe, one byte per cycle when high |
| cfgMode | output | 1 | Configuration mode is active |
| cfgBase | output | 16 | Selected base address, 0 when not in configuration mode |

## Verification
Every result is registered once. The write sampled at a rising edge changes `cfgMode` and `cfgBase` at that same edge, so both are due one cycle after the stimulus. Nothing in the block reacts combinationally to the bus. The bench applies each write on a falling edge and holds it through one rising edge. It then samples the outputs at the next falling edge, which is the first point where the result is due. Checks that a flag stays low or stays high are made right after the deciding byte, such as the 31st key byte, a wrong index, or an ignored strobe-low cycle.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

  // Sequencer stages: prefix progress, key stage, configuration mode
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOT86,
    ST_GOT80,
    ST_GOT55,
    ST_GOTAA,
    ST_KEY,
    ST_CONFIG
  } seqState_t;

  // Which base address the prefix picked
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_A,
    SEL_B,
    SEL_C
  } baseSel_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic     keyRestart;
    logic     keyAdvance;
    logic     baseLoad;
    baseSel_t baseSel;
    logic     idxLoad;
  } dpStrobe_t;

  // Prefix byte values; their order is part of the entry protocol
  localparam logic [7:0] PFX_FIRST  = 8'h86;
  localparam logic [7:0] PFX_SECOND = 8'h80;
  localparam logic [7:0] PFX_LO     = 8'h55;
  localparam logic [7:0] PFX_HI     = 8'hAA;

  // Exit command: this value written to this configuration index
  localparam logic [7:0] EXIT_INDEX = 8'h02;
  localparam logic [7:0] EXIT_VALUE = 8'h02;

endpackage

// File: rtl/cfg_unlock_dp.sv
module cfg_unlock_dp
  import cfg_unlock_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int KEY_LEN = 32,
  parameter logic [DATA_W-1:0] KEY_SEED = 8'h6A,
  parameter logic [ADDR_W-1:0] BASE_A = 16'h03F0,
  parameter logic [ADDR_W-1:0] BASE_B = 16'h03BD,
  parameter logic [ADDR_W-1:0] BASE_C = 16'h0370
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] keyExpect,
  output logic              keyLast,
  output logic [ADDR_W-1:0] selBase,
  output logic [DATA_W-1:0] idxValue
);

  localparam int CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(KEY_LEN - 1);

  logic [DATA_W-1:0] keyQ;
  logic [CNT_W-1:0]  keyCntQ;
  logic [ADDR_W-1:0] baseQ;
  logic [DATA_W-1:0] idxQ;
  logic [ADDR_W-1:0] baseLoadVal;

  // One step of the key generator: shift right, feedback into the top bit
  function automatic logic [DATA_W-1:0] keyStep(input logic [DATA_W-1:0] v);
    return {v[0] ^ v[1], v[DATA_W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      keyQ    <= KEY_SEED;
      keyCntQ <= '0;
    end else if (strobe.keyRestart) begin
      keyQ    <= KEY_SEED;
      keyCntQ <= '0;
    end else if (strobe.keyAdvance) begin
      keyQ    <= keyStep(keyQ);
      keyCntQ <= keyCntQ + CNT_W'(1);
    end
  end

  always_comb begin
    unique case (strobe.baseSel)
      SEL_A:   baseLoadVal = BASE_A;
      SEL_B:   baseLoadVal = BASE_B;
      SEL_C:   baseLoadVal = BASE_C;
      default: baseLoadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ <= '0;
      idxQ  <= '0;
    end else begin
      if (strobe.baseLoad) baseQ <= baseLoadVal;
      if (strobe.idxLoad)  idxQ  <= wrData;
    end
  end

  assign keyExpect = keyQ;
  assign keyLast   = (keyCntQ == LAST_CNT);
  assign selBase   = baseQ;
  assign idxValue  = idxQ;

endmodule

// File: rtl/cfg_unlock_ctl.sv
module cfg_unlock_ctl
  import cfg_unlock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0279
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] keyExpect,
  input  logic              keyLast,
  input  logic [ADDR_W-1:0] selBase,
  input  logic [DATA_W-1:0] idxValue,
  output dpStrobe_t         strobe,
  output logic              cfgMode
);

  seqState_t stQ, stNext;
  logic      cfgModeQ;
  logic      hitPort, hitBase, hitData;
  seqState_t restartSt;

  assign hitPort = ioWr && (ioAddr == PORT_ADDR);
  assign hitBase = ioWr && (ioAddr == selBase);
  assign hitData = ioWr && (ioAddr == selBase + ADDR_W'(1));

  // A wrong prefix byte that is itself the first prefix byte restarts the prefix
  assign restartSt = (ioData == DATA_W'(PFX_FIRST)) ? ST_GOT86 : ST_IDLE;

  always_comb begin
    stNext = stQ;
    strobe = '0;
    strobe.baseSel = SEL_NONE;
    unique case (stQ)
      ST_IDLE: begin
        if (hitPort && ioData == DATA_W'(PFX_FIRST)) stNext = ST_GOT86;
      end
      ST_GOT86: begin
        if (hitPort) stNext = (ioData == DATA_W'(PFX_SECOND)) ? ST_GOT80 : restartSt;
      end
      ST_GOT80: begin
        if (hitPort) begin
          if (ioData == DATA_W'(PFX_LO))      stNext = ST_GOT55;
          else if (ioData == DATA_W'(PFX_HI)) stNext = ST_GOTAA;
          else                                stNext = restartSt;
        end
      end
      ST_GOT55: begin
        if (hitPort) begin
          if (ioData == DATA_W'(PFX_LO) || ioData == DATA_W'(PFX_HI)) begin
            stNext            = ST_KEY;
            strobe.baseLoad   = 1'b1;
            strobe.keyRestart = 1'b1;
            strobe.baseSel    = (ioData == DATA_W'(PFX_LO)) ? SEL_A : SEL_B;
          end else begin
            stNext = restartSt;
          end
        end
      end
      ST_GOTAA: begin
        if (hitPort) begin
          if (ioData == DATA_W'(PFX_LO)) begin
            stNext            = ST_KEY;
            strobe.baseLoad   = 1'b1;
            strobe.keyRestart = 1'b1;
            strobe.baseSel    = SEL_C;
          end else begin
            stNext = restartSt;
          end
        end
      end
      ST_KEY: begin
        if (hitBase) begin
          if (ioData == keyExpect) begin
            if (keyLast) stNext = ST_CONFIG;
            else         strobe.keyAdvance = 1'b1;
          end else begin
            stNext = ST_IDLE;
          end
        end
      end
      ST_CONFIG: begin
        if (hitBase) begin
          strobe.idxLoad = 1'b1;
        end else if (hitData && idxValue == DATA_W'(EXIT_INDEX)
                     && ioData == DATA_W'(EXIT_VALUE)) begin
          stNext = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ      <= ST_IDLE;
      cfgModeQ <= 1'b0;
    end else begin
      stQ      <= stNext;
      cfgModeQ <= (stNext == ST_CONFIG);
    end
  end

  assign cfgMode = cfgModeQ;

endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
  import cfg_unlock_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int KEY_LEN = 32,
  parameter logic [DATA_W-1:0] KEY_SEED  = 8'h6A,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0279,
  parameter logic [ADDR_W-1:0] BASE_A    = 16'h03F0,
  parameter logic [ADDR_W-1:0] BASE_B    = 16'h03BD,
  parameter logic [ADDR_W-1:0] BASE_C    = 16'h0370
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioWr,
  output logic              cfgMode,
  output logic [ADDR_W-1:0] cfgBase
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] keyExpect;
  logic              keyLast;
  logic [ADDR_W-1:0] selBase;
  logic [DATA_W-1:0] idxValue;

  cfg_unlock_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
  ) u_ctl (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioData(ioData), .ioWr(ioWr),
    .keyExpect(keyExpect), .keyLast(keyLast), .selBase(selBase),
    .idxValue(idxValue), .strobe(strobe), .cfgMode(cfgMode)
  );

  cfg_unlock_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .KEY_SEED(KEY_SEED),
    .BASE_A(BASE_A), .BASE_B(BASE_B), .BASE_C(BASE_C)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(ioData),
    .keyExpect(keyExpect), .keyLast(keyLast), .selBase(selBase),
    .idxValue(idxValue)
  );

  assign cfgBase = cfgMode ? selBase : '0;

endmodule

// File: rtl/cfg_unlock_seq_chk.sv
module cfg_unlock_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_A = 16'h03F0,
  parameter logic [ADDR_W-1:0] BASE_B = 16'h03BD,
  parameter logic [ADDR_W-1:0] BASE_C = 16'h0370
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioData,
  input logic              ioWr,
  input logic              cfgMode,
  input logic [ADDR_W-1:0] cfgBase
);

  // R1: reset leaves the mode flag low and the base at zero
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!cfgMode && cfgBase == '0));

  // R4: entry happens only on a write to the base being reported
  a_r4_entry_on_base_write: assert property (@(posedge clk) disable iff (rst)
    $rose(cfgMode) |-> ($past(ioWr) && $past(ioAddr) == cfgBase));

  // R3: only the three legal bases can be reported in configuration mode
  a_r3_legal_base: assert property (@(posedge clk) disable iff (rst)
    cfgMode |-> (cfgBase == BASE_A || cfgBase == BASE_B || cfgBase == BASE_C));

  // R8: leaving needs the exit value written to the data port
  a_r8_exit_on_data_write: assert property (@(posedge clk) disable iff (rst)
    $fell(cfgMode) |-> ($past(ioWr) && $past(ioData) == DATA_W'(8'h02)
                        && $past(ioAddr) == $past(cfgBase) + ADDR_W'(1)));

  // R7: idle bus cycles change nothing visible
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !ioWr |=> ($stable(cfgMode) && $stable(cfgBase)));

  // R9: base stays fixed while the mode flag stays up
  a_r9_base_held: assert property (@(posedge clk) disable iff (rst)
    (cfgMode && $past(cfgMode)) |-> $stable(cfgBase));

  // R9: base reads zero outside configuration mode
  a_r9_base_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !cfgMode |-> (cfgBase == '0));

endmodule

bind cfg_unlock_seq cfg_unlock_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .BASE_A(BASE_A), .BASE_B(BASE_B), .BASE_C(BASE_C)
) u_chk (
  .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioData(ioData), .ioWr(ioWr),
  .cfgMode(cfgMode), .cfgBase(cfgBase)
);

// File: tb/cfg_unlock_seq_bench.sv
`timescale 1ns/1ps
module cfg_unlock_seq_bench;

  localparam logic [15:0] PORT = 16'h0279;
  localparam logic [15:0] BA   = 16'h03F0;
  localparam logic [15:0] BB   = 16'h03BD;
  localparam logic [15:0] BC   = 16'h0370;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioData = '0;
  logic        ioWr = 1'b0;
  logic        cfgMode;
  logic [15:0] cfgBase;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_unlock_seq u_cfg_unlock_seq (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioData(ioData), .ioWr(ioWr),
    .cfgMode(cfgMode), .cfgBase(cfgBase)
  );

  function automatic logic [7:0] nextKey(input logic [7:0] v);
    return {v[0] ^ v[1], v[7:1]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic idleBus(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioData = d; ioWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic prefix(input logic [7:0] b2, input logic [7:0] b3);
    wr(PORT, 8'h86); wr(PORT, 8'h80); wr(PORT, b2); wr(PORT, b3);
  endtask

  // Send key bytes with positions first..last (0-based) to a base
  task automatic keyRange(input logic [15:0] base, input int first, input int last);
    logic [7:0] k = 8'h6A;
    for (int i = 0; i < 32; i++) begin
      if (i >= first && i <= last) wr(base, k);
      k = nextKey(k);
    end
  endtask

  task automatic exitCfg(input logic [15:0] base, input string req);
    wr(base, 8'h02);
    wr(base + 16'd1, 8'h02);
    check(req, "mode after exit", {31'd0, cfgMode}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1", "mode at reset", {31'd0, cfgMode}, 32'd0);
    check("R1", "base at reset", {16'd0, cfgBase}, 32'd0);
  endtask

  task automatic t_keyValues;
    logic [7:0] k = 8'h6A;
    logic [7:0] seen[32];
    for (int i = 0; i < 32; i++) begin seen[i] = k; k = nextKey(k); end
    check("R4", "key byte 1", {24'd0, seen[1]}, 32'hB5);
    check("R4", "key byte 7", {24'd0, seen[7]}, 32'hBE);
    check("R4", "key byte 31", {24'd0, seen[31]}, 32'h39);
  endtask

  task automatic t_baseA;
    prefix(8'h55, 8'h55);
    keyRange(BA, 0, 30);
    check("R4", "mode after 31 bytes", {31'd0, cfgMode}, 32'd0);
    check("R9", "base before entry", {16'd0, cfgBase}, 32'd0);
    keyRange(BA, 31, 31);
    check("R2", "mode after key A", {31'd0, cfgMode}, 32'd1);
    check("R2", "base A", {16'd0, cfgBase}, {16'd0, BA});
    wr(BA, 8'h02);
    wr(BA + 16'd1, 8'h03);
    check("R8", "wrong exit value keeps mode", {31'd0, cfgMode}, 32'd1);
    wr(BA, 8'h07);
    wr(BA + 16'd1, 8'h02);
    check("R8", "wrong exit index keeps mode", {31'd0, cfgMode}, 32'd1);
    exitCfg(BA, "R8");
    check("R9", "base after exit", {16'd0, cfgBase}, 32'd0);
  endtask

  task automatic t_baseB;
    prefix(8'h55, 8'hAA);
    keyRange(BB, 0, 31);
    check("R3", "mode after key B", {31'd0, cfgMode}, 32'd1);
    check("R3", "base B", {16'd0, cfgBase}, {16'd0, BB});
    exitCfg(BB, "R8");
  endtask

  task automatic t_baseC;
    prefix(8'hAA, 8'h55);
    keyRange(BC, 0, 31);
    check("R3", "mode after key C", {31'd0, cfgMode}, 32'd1);
    check("R3", "base C", {16'd0, cfgBase}, {16'd0, BC});
    exitCfg(BC, "R8");
  endtask

  task automatic t_badPrefix;
    prefix(8'hAA, 8'hAA);
    keyRange(BC, 0, 31);
    check("R3", "AA AA selects nothing", {31'd0, cfgMode}, 32'd0);
    wr(PORT, 8'h86); wr(PORT, 8'h80); wr(PORT, 8'h12); wr(PORT, 8'h55); wr(PORT, 8'h55);
    keyRange(BA, 0, 31);
    check("R5", "wrong prefix byte resets", {31'd0, cfgMode}, 32'd0);
  endtask

  task automatic t_restart86;
    wr(PORT, 8'h86); wr(PORT, 8'h80); wr(PORT, 8'h86);
    wr(PORT, 8'h80); wr(PORT, 8'h55); wr(PORT, 8'h55);
    keyRange(BA, 0, 31);
    check("R5", "0x86 restarts prefix", {31'd0, cfgMode}, 32'd1);
    exitCfg(BA, "R8");
  endtask

  task automatic t_wrongKey;
    prefix(8'h55, 8'h55);
    keyRange(BA, 0, 9);
    wr(BA, 8'h00);
    keyRange(BA, 10, 31);
    check("R6", "wrong key byte aborts", {31'd0, cfgMode}, 32'd0);
    prefix(8'h55, 8'h55);
    keyRange(BA, 0, 31);
    check("R6", "recovers after new prefix", {31'd0, cfgMode}, 32'd1);
    exitCfg(BA, "R8");
  endtask

  task automatic t_ignored;
    wr(PORT, 8'h86);
    wr(16'h0080, 8'h12);
    idleBus(PORT, 8'h00);
    wr(PORT, 8'h80);
    wr(16'h0278, 8'h00);
    wr(PORT, 8'hAA);
    idleBus(PORT, 8'h86);
    wr(PORT, 8'h55);
    keyRange(BC, 0, 15);
    wr(PORT, 8'h33);
    wr(BA, 8'h00);
    idleBus(BC, 8'hFF);
    keyRange(BC, 16, 31);
    check("R7", "foreign writes ignored", {31'd0, cfgMode}, 32'd1);
    check("R7", "base kept", {16'd0, cfgBase}, {16'd0, BC});
    wr(BC, 8'h02);
    idleBus(BC + 16'd1, 8'h02);
    check("R7", "strobe low ignored in config", {31'd0, cfgMode}, 32'd1);
    wr(PORT, 8'h02);
    wr(16'h0100, 8'h02);
    check("R7", "other address in config ignored", {31'd0, cfgMode}, 32'd1);
    wr(BC + 16'd1, 8'h02);
    check("R8", "exit with kept index", {31'd0, cfgMode}, 32'd0);
  endtask

  task automatic t_midReset;
    prefix(8'h55, 8'h55);
    keyRange(BA, 0, 31);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", "reset leaves config", {31'd0, cfgMode}, 32'd0);
    check("R1", "reset clears base", {16'd0, cfgBase}, 32'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_keyValues();
    t_baseA();
    t_baseB();
    t_baseC();
    t_badPrefix();
    t_restart86();
    t_wrongKey();
    t_ignored();
    t_midReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule